// File: doc/BRIEF.md
# Enable-Gated Test Access Port with Emulation Scan Path

This block is the test access port of a processor core. A sixteen-state controller is clocked by the test clock and steered by the mode-select input. It sequences scans through a 4-bit instruction register and through one data register, which the decoded instruction picks. The data register is a one-bit bypass stage, a 32-bit identification register, or an external emulation register port. For the emulation port the block does not hold the data. It passes TDI through, returns the port's serial output on TDO, and gives the port select, capture, shift and update strobes. These strobes are timed by the same capture, shift and update states that every other data register uses.

The controller listens to its inputs only while the separate core enable input is high. This lets several test ports share one set of pins, with the chip-level logic deciding which port sees the test clock activity. An active-low reset returns the controller to its reset state at once, without waiting for a clock edge. TDO is launched on the falling test-clock edge and is qualified by an output-enable flag.

Top module: `jtag_gated_tap`

## Requirements
- R1: Driving `rst_n` low puts the controller into Test-Logic-Reset at once, with no clock edge needed. It loads the identification instruction 4'b0010, clears `tdo_oe` and `tdo`, and drops `emu_sel`.
- R2: State changes happen on the rising edge of `tck`, following the standard sixteen-state transition graph. Five rising edges with `tms` high reach Test-Logic-Reset from any state, and that state reloads the identification instruction.
- R3: While `tap_en` is low, rising edges of `tck` leave the controller state unchanged. They also leave every shift, instruction and bypass register unchanged, and all emulation strobes stay low.
- R4: In Capture-IR the instruction shift stage loads 4'b0001. In Shift-IR it shifts TDI in at bit 3, and bit 0 appears first on TDO.
- R5: The decoded instruction changes only at a rising edge that leaves Update-IR, or when the controller enters Test-Logic-Reset. Shifting a new instruction does not change it.
- R6: With instruction 4'b0010, Capture-DR loads the 32-bit identification value with bit 0 forced to 1. The default value reads back as 32'h5E1C702F. It shifts out LSB first, with bit 0 on TDO in the first Shift-DR cycle.
- R7: Instruction 4'b1111 selects the bypass stage, and so does every encoding not assigned to another register. The stage captures 0 and delays TDI by one Shift-DR cycle.
- R8: With instruction 4'b0111, `emu_sel` is high. `emu_capture`, `emu_shift` and `emu_update` are each high during one Capture-DR, Shift-DR or Update-DR cycle respectively, and only while `tap_en` is high. `emu_tdi` follows TDI, and TDO returns `emu_tdo`. With any other instruction the three strobes stay low.
- R9: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR, and `tdo` is 0 whenever `tdo_oe` is low.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| tap_en | input | 1 | Core enable; the controller follows tck/tms only while high |
| tms | input | 1 | Mode select, sampled on the rising edge of tck |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, launched on the falling edge |
| tdo_oe | output | 1 | TDO valid / output-enable flag |
| emu_tdi | output | 1 | Serial data toward the emulation register port |
| emu_tdo | input | 1 | Serial data returned from the emulation register port |
| emu_sel | output | 1 | Emulation instruction is active |
| emu_capture | output | 1 | Emulation port capture strobe |
| emu_shift | output | 1 | Emulation port shift strobe |
| emu_update | output | 1 | Emulation port update strobe |

## Verification
Two things can fall in the same cycle: the core enable dropping, and the controller sitting in an update state. One case is Update-IR, where the decoded instruction would change. The other is Update-DR, where the emulation update strobe would fire. The bench parks the controller in each update state and drops `tap_en` for several clock edges with `tms` high. It confirms that `emu_sel` keeps its old value and that no update pulse reaches the emulation port model. It then confirms that exactly one update takes effect once the enable returns. The same clash is provoked mid-shift, and the bench judges it by an unbroken emulation readout.

// File: rtl/jtag_tap_pkg.sv
// Shared types for the gated test access port: the sixteen controller
// states and their next-state function. The encodings follow the
// common scan-controller assignment; nothing outside this block decodes them.
package jtag_tap_pkg;

    typedef enum logic [3:0] {
        TAP_EX2_DR  = 4'h0,
        TAP_EX1_DR  = 4'h1,
        TAP_SH_DR   = 4'h2,
        TAP_PA_DR   = 4'h3,
        TAP_SEL_IR  = 4'h4,
        TAP_UPD_DR  = 4'h5,
        TAP_CAP_DR  = 4'h6,
        TAP_SEL_DR  = 4'h7,
        TAP_EX2_IR  = 4'h8,
        TAP_EX1_IR  = 4'h9,
        TAP_SH_IR   = 4'hA,
        TAP_PA_IR   = 4'hB,
        TAP_IDLE    = 4'hC,
        TAP_UPD_IR  = 4'hD,
        TAP_CAP_IR  = 4'hE,
        TAP_RESET   = 4'hF
    } tap_state_t;

    // Next state of the controller for a given mode-select value.
    function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
        case (s)
            TAP_RESET:  return m ? TAP_RESET  : TAP_IDLE;
            TAP_IDLE:   return m ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_DR: return m ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR: return m ? TAP_EX1_DR : TAP_SH_DR;
            TAP_SH_DR:  return m ? TAP_EX1_DR : TAP_SH_DR;
            TAP_EX1_DR: return m ? TAP_UPD_DR : TAP_PA_DR;
            TAP_PA_DR:  return m ? TAP_EX2_DR : TAP_PA_DR;
            TAP_EX2_DR: return m ? TAP_UPD_DR : TAP_SH_DR;
            TAP_UPD_DR: return m ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_IR: return m ? TAP_RESET  : TAP_CAP_IR;
            TAP_CAP_IR: return m ? TAP_EX1_IR : TAP_SH_IR;
            TAP_SH_IR:  return m ? TAP_EX1_IR : TAP_SH_IR;
            TAP_EX1_IR: return m ? TAP_UPD_IR : TAP_PA_IR;
            TAP_PA_IR:  return m ? TAP_EX2_IR : TAP_PA_IR;
            TAP_EX2_IR: return m ? TAP_UPD_IR : TAP_SH_IR;
            TAP_UPD_IR: return m ? TAP_SEL_DR : TAP_IDLE;
            default:    return TAP_RESET;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state scan controller.
// Does: advances on the rising test-clock edge using the sampled mode select.
// Assumes: rst_n is asynchronous active-low; tap_en low freezes the state.
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tap_en,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t state_q;
    tap_state_t state_d;

    // Next-state lookup for the current mode select.
    always_comb state_d = tap_next(state_q, tms);

    // State register: async reset, advances only while enabled.
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)      state_q <= TAP_RESET;
        else if (tap_en) state_q <= state_d;
    end

    assign state = state_q;

    assert_hold_when_disabled_R3: assert property (
        @(posedge tck) disable iff (!rst_n)
        !tap_en |=> $stable(state_q));

    assert_reset_sticky_R2: assert property (
        @(posedge tck) disable iff (!rst_n)
        (tap_en && tms && state_q == TAP_RESET) |=> (state_q == TAP_RESET));

endmodule

// File: rtl/tap_ir.sv
// Instruction register: a shift stage plus the decoded-instruction holder.
// Does: captures the fixed ...01 pattern, shifts LSB first, updates on Update-IR.
// Assumes: IR_W >= 2; RESET_OP is the instruction loaded in Test-Logic-Reset.
module tap_ir
    import jtag_tap_pkg::*;
#(
    parameter int              IR_W     = 4,
    parameter logic [IR_W-1:0] RESET_OP = '1
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tap_en,
    input  tap_state_t      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_out
);

    localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-1){1'b0}}, 1'b1};

    logic [IR_W-1:0] ir_sr;

    // Shift stage: capture the fixed pattern, then shift TDI in at the top.
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            ir_sr <= CAP_PAT;
        end else if (tap_en) begin
            if (state == TAP_CAP_IR)     ir_sr <= CAP_PAT;
            else if (state == TAP_SH_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end
    end

    // Decoded instruction: reload on reset state, take new value on update.
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            ir_q <= RESET_OP;
        end else if (tap_en) begin
            if (state == TAP_RESET)       ir_q <= RESET_OP;
            else if (state == TAP_UPD_IR) ir_q <= ir_sr;
        end
    end

    assign ir_out = ir_sr[0];

    assert_ir_changes_on_update_R5: assert property (
        @(posedge tck) disable iff (!rst_n)
        !(tap_en && (state == TAP_UPD_IR || state == TAP_RESET)) |=> $stable(ir_q));

    assert_capture_lsb_one_R4: assert property (
        @(posedge tck) disable iff (!rst_n)
        (tap_en && state == TAP_CAP_IR) |=> (ir_out == 1'b1));

endmodule

// File: rtl/tap_dr.sv
// Data-register side: bypass stage, optional identification register and
// the strobes toward the external emulation register port.
// Does: picks the serial source for Shift-DR from the decoded instruction.
// Assumes: EMU_OP differs from the all-ones bypass code; unknown codes bypass.
module tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int              IR_W       = 4,
    parameter logic [IR_W-1:0] IDCODE_OP  = 4'b0010,
    parameter logic [IR_W-1:0] EMU_OP     = 4'b0111,
    parameter bit              HAS_IDCODE = 1'b1,
    parameter int              ID_W       = 32,
    parameter logic [ID_W-1:0] ID_VALUE   = 32'h5E1C_702E
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tap_en,
    input  tap_state_t      state,
    input  logic            tdi,
    input  logic [IR_W-1:0] ir_q,
    input  logic            emu_tdo,
    output logic            dr_bit,
    output logic            emu_sel,
    output logic            emu_capture,
    output logic            emu_shift,
    output logic            emu_update
);

    logic byp_q;
    logic id_bit;
    logic id_sel;

    assign emu_sel = (ir_q == EMU_OP);

    generate
        if (HAS_IDCODE) begin : g_id
            localparam logic [ID_W-1:0] ID_CAP = {ID_VALUE[ID_W-1:1], 1'b1};
            logic [ID_W-1:0] id_sr;

            // Identification register: capture the value, shift LSB first.
            always_ff @(posedge tck or negedge rst_n) begin
                if (!rst_n) begin
                    id_sr <= ID_CAP;
                end else if (tap_en && id_sel) begin
                    if (state == TAP_CAP_DR)     id_sr <= ID_CAP;
                    else if (state == TAP_SH_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
                end
            end

            assign id_sel = (ir_q == IDCODE_OP);
            assign id_bit = id_sr[0];
        end else begin : g_no_id
            assign id_sel = 1'b0;
            assign id_bit = 1'b0;
        end
    endgenerate

    // Bypass stage: clear on capture, one-bit delay during shift.
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            byp_q <= 1'b0;
        end else if (tap_en) begin
            if (state == TAP_CAP_DR)     byp_q <= 1'b0;
            else if (state == TAP_SH_DR) byp_q <= tdi;
        end
    end

    // Serial source select and emulation port strobes.
    always_comb begin
        dr_bit      = emu_sel ? emu_tdo : (id_sel ? id_bit : byp_q);
        emu_capture = tap_en && emu_sel && (state == TAP_CAP_DR);
        emu_shift   = tap_en && emu_sel && (state == TAP_SH_DR);
        emu_update  = tap_en && emu_sel && (state == TAP_UPD_DR);
    end

    assert_bypass_captures_zero_R7: assert property (
        @(posedge tck) disable iff (!rst_n)
        (tap_en && state == TAP_CAP_DR) |=> (byp_q == 1'b0));

endmodule

// File: rtl/jtag_gated_tap.sv
// Top of the enable-gated test access port.
// Does: ties the controller, instruction register and data-register side
// together and launches TDO with its enable on the falling test-clock edge.
// Assumes: rst_n is asynchronous; tap_en is steady around rising tck edges.
module jtag_gated_tap
    import jtag_tap_pkg::*;
#(
    parameter int              IR_W       = 4,
    parameter logic [IR_W-1:0] IDCODE_OP  = 4'b0010,
    parameter logic [IR_W-1:0] EMU_OP     = 4'b0111,
    parameter bit              HAS_IDCODE = 1'b1,
    parameter logic [31:0]     ID_VALUE   = 32'h5E1C_702E
) (
    input  logic tck,
    input  logic rst_n,
    input  logic tap_en,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe,
    output logic emu_tdi,
    input  logic emu_tdo,
    output logic emu_sel,
    output logic emu_capture,
    output logic emu_shift,
    output logic emu_update
);

    localparam logic [IR_W-1:0] BYPASS_OP = '1;
    localparam logic [IR_W-1:0] RESET_OP  = HAS_IDCODE ? IDCODE_OP : BYPASS_OP;

    tap_state_t      state;
    logic [IR_W-1:0] ir_q;
    logic            ir_out;
    logic            dr_bit;
    logic            tdo_q;
    logic            oe_q;
    logic            in_shift;

    tap_fsm u_fsm (
        .tck    (tck),
        .rst_n  (rst_n),
        .tap_en (tap_en),
        .tms    (tms),
        .state  (state)
    );

    tap_ir #(
        .IR_W     (IR_W),
        .RESET_OP (RESET_OP)
    ) u_ir (
        .tck    (tck),
        .rst_n  (rst_n),
        .tap_en (tap_en),
        .state  (state),
        .tdi    (tdi),
        .ir_q   (ir_q),
        .ir_out (ir_out)
    );

    tap_dr #(
        .IR_W       (IR_W),
        .IDCODE_OP  (IDCODE_OP),
        .EMU_OP     (EMU_OP),
        .HAS_IDCODE (HAS_IDCODE),
        .ID_W       (32),
        .ID_VALUE   (ID_VALUE)
    ) u_dr (
        .tck         (tck),
        .rst_n       (rst_n),
        .tap_en      (tap_en),
        .state       (state),
        .tdi         (tdi),
        .ir_q        (ir_q),
        .emu_tdo     (emu_tdo),
        .dr_bit      (dr_bit),
        .emu_sel     (emu_sel),
        .emu_capture (emu_capture),
        .emu_shift   (emu_shift),
        .emu_update  (emu_update)
    );

    assign in_shift = (state == TAP_SH_IR) || (state == TAP_SH_DR);

    // Output stage: launch the serial bit and its enable on the falling edge.
    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            tdo_q <= (state == TAP_SH_IR) ? ir_out : dr_bit;
            oe_q  <= in_shift;
        end
    end

    assign tdo     = oe_q & tdo_q;
    assign tdo_oe  = oe_q;
    assign emu_tdi = tdi;

    assert_oe_only_in_shift_R9: assert property (
        @(posedge tck) disable iff (!rst_n)
        tdo_oe |-> in_shift);

    assert_emu_return_path_R8: assert property (
        @(negedge tck) disable iff (!rst_n)
        emu_shift |=> (tdo == $past(emu_tdo)));

endmodule

// File: tb/jtag_gated_tap_bench.sv
// Self-checking bench: sweeps every instruction code, walks the controller
// through all states, and collides the enable with update and shift states.
module jtag_gated_tap_bench;

    localparam int          TCK_P   = 20;
    localparam logic [3:0]  OP_ID   = 4'b0010;
    localparam logic [3:0]  OP_EMU  = 4'b0111;
    localparam logic [3:0]  OP_BYP  = 4'b1111;
    localparam logic [31:0] ID_EXP  = 32'h5E1C_702F;
    localparam logic [7:0]  EMU_CAP = 8'hA5;
    localparam int          WALK[17] = '{1,0,0,1,0,1,0,1,1,1,1,0,0,1,0,1,1};

    logic tck = 1'b0;
    logic rst_n, tap_en, tms, tdi;
    logic tdo, tdo_oe, emu_tdi, emu_tdo, emu_sel;
    logic emu_capture, emu_shift, emu_update;

    int n_chk = 0;
    int n_fail = 0;
    int oe_err = 0;
    int low_err = 0;
    logic so, soe;

    // Emulation register port model: 8-bit register with event counters.
    logic [7:0] emu_m = 8'h00;
    int cap_n = 0;
    int sh_n = 0;
    int up_n = 0;

    jtag_gated_tap u_jtag_gated_tap (
        .tck         (tck),
        .rst_n       (rst_n),
        .tap_en      (tap_en),
        .tms         (tms),
        .tdi         (tdi),
        .tdo         (tdo),
        .tdo_oe      (tdo_oe),
        .emu_tdi     (emu_tdi),
        .emu_tdo     (emu_tdo),
        .emu_sel     (emu_sel),
        .emu_capture (emu_capture),
        .emu_shift   (emu_shift),
        .emu_update  (emu_update)
    );

    always #(TCK_P/2) tck = ~tck;

    always @(posedge tck) begin
        if (emu_capture)    emu_m <= EMU_CAP;
        else if (emu_shift) emu_m <= {emu_tdi, emu_m[7:1]};
        if (emu_capture) cap_n <= cap_n + 1;
        if (emu_shift)   sh_n  <= sh_n + 1;
        if (emu_update)  up_n  <= up_n + 1;
    end
    assign emu_tdo = emu_m[0];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One test clock: drive, sample after the falling edge, end after the rising edge.
    task automatic tick(input logic m, input logic d, input int eo);
        tms = m;
        tdi = d;
        @(negedge tck);
        #1;
        so  = tdo;
        soe = tdo_oe;
        if (eo >= 0 && soe !== eo[0]) oe_err++;
        if (soe !== 1'b1 && so !== 1'b0) low_err++;
        @(posedge tck);
        #1;
    endtask

    task automatic shift_bits(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], 1);
            dout[i] = so;
        end
    endtask

    task automatic enter_dr();
        tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
    endtask

    task automatic enter_ir();
        tick(1, 0, 0); tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
    endtask

    task automatic leave();
        tick(1, 0, 0); tick(0, 0, 0);
    endtask

    task automatic scan_ir(input logic [3:0] op, output logic [3:0] rd);
        logic [31:0] d;
        enter_ir();
        shift_bits(4, {28'd0, op}, d);
        rd = d[3:0];
        leave();
    endtask

    task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        enter_dr();
        shift_bits(n, din, dout);
        leave();
    endtask

    task automatic goto_idle();
        repeat (5) tick(1, 0, -1);
        tick(0, 0, -1);
    endtask

    initial begin
        repeat (50000) @(posedge tck);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [3:0]  ir_o;
        logic [31:0] d;
        logic [31:0] din;
        int c0, s0, u0;

        rst_n = 1'b0; tap_en = 1'b1; tms = 1'b1; tdi = 1'b0;
        repeat (2) @(posedge tck);
        #3;
        chk("R1 tdo_oe in reset", {31'd0, tdo_oe}, 0);
        chk("R1 tdo in reset", {31'd0, tdo}, 0);
        chk("R1 emu_sel in reset", {31'd0, emu_sel}, 0);
        @(posedge tck); #1;
        rst_n = 1'b1;
        goto_idle();
        scan_dr(32, 32'h0, d);
        chk("R1/R6 identification after reset", d, ID_EXP);

        scan_ir(OP_BYP, ir_o);
        chk("R4 IR capture pattern", {28'd0, ir_o}, 32'h1);
        scan_dr(9, 32'h1B5, d);
        chk("R7 bypass delay", d, {23'd0, 8'hB5, 1'b0});

        // Sweep of every instruction code.
        for (int op = 0; op < 16; op++) begin
            scan_ir(op[3:0], ir_o);
            chk("R4 IR capture in sweep", {28'd0, ir_o}, 32'h1);
            chk("R8 emu_sel decode", {31'd0, emu_sel}, {31'd0, op[3:0] == OP_EMU});
            c0 = cap_n; s0 = sh_n; u0 = up_n;
            if (op[3:0] == OP_ID) begin
                scan_dr(32, 32'hFFFF_0000, d);
                chk("R6 identification readout", d, ID_EXP);
                scan_dr(32, 32'h1234_5678, d);
                chk("R6 identification recapture", d, ID_EXP);
            end else if (op[3:0] == OP_EMU) begin
                scan_dr(8, 32'h3C, d);
                chk("R8 emulation readout", d, {24'd0, EMU_CAP});
                chk("R8 emulation written", {24'd0, emu_m}, 32'h3C);
                chk("R8 capture strobes", cap_n - c0, 1);
                chk("R8 shift strobes", sh_n - s0, 8);
                chk("R8 update strobes", up_n - u0, 1);
            end else begin
                din = (op * 73 + 5) & 32'h1FF;
                scan_dr(9, din, d);
                chk("R7 bypass for code", d, {23'd0, din[7:0], 1'b0});
                chk("R8 no strobes off emulation", (cap_n - c0) + (sh_n - s0) + (up_n - u0), 0);
            end
        end

        // TDO launch edge: with the ID in Shift-DR, bit 3 holds until the falling edge.
        scan_ir(OP_ID, ir_o);
        enter_dr();
        repeat (4) tick(0, 0, 1);
        chk("R9 tdo holds past rising edge", {31'd0, tdo}, {31'd0, ID_EXP[3]});
        @(negedge tck); #1;
        chk("R9 tdo moves on falling edge", {31'd0, tdo}, {31'd0, ID_EXP[4]});
        @(posedge tck); #1;
        tick(1, 0, 1);
        leave();

        // Disabled controller ignores a reset-walk of ones.
        scan_ir(OP_BYP, ir_o);
        tap_en = 1'b0;
        repeat (6) tick(1, 0, 0);
        tap_en = 1'b1;
        scan_dr(9, 32'h0A6, d);
        chk("R3 instruction survives disabled ones", d, {23'd0, 8'hA6, 1'b0});

        // Enable dropped in the middle of an emulation shift.
        scan_ir(OP_EMU, ir_o);
        s0 = sh_n;
        din = 32'h3C;
        d = '0;
        enter_dr();
        for (int i = 0; i < 3; i++) begin
            tick(0, din[i], 1);
            d[i] = so;
        end
        tap_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick(1, i[0], 1);
            chk("R3 tdo frozen while disabled", {31'd0, so}, {31'd0, EMU_CAP[3]});
            chk("R3 no shift strobe while disabled", {31'd0, emu_shift}, 0);
        end
        tap_en = 1'b1;
        for (int i = 3; i < 8; i++) begin
            tick(i == 7, din[i], 1);
            d[i] = so;
        end
        leave();
        chk("R3 continuous emulation readout", d, {24'd0, EMU_CAP});
        chk("R3 emulation register written", {24'd0, emu_m}, din);
        chk("R3 shift count across pause", sh_n - s0, 8);

        // Enable dropped while in Update-IR.
        enter_ir();
        shift_bits(4, {28'd0, OP_BYP}, d);
        chk("R5 shifting leaves instruction", {31'd0, emu_sel}, 1);
        tick(1, 0, 0);
        tap_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick(1, 0, 0);
            chk("R5 no update while disabled", {31'd0, emu_sel}, 1);
        end
        tap_en = 1'b1;
        tick(0, 0, 0);
        chk("R5 update after enable", {31'd0, emu_sel}, 0);

        // Enable dropped while in Update-DR.
        scan_ir(OP_EMU, ir_o);
        u0 = up_n;
        enter_dr();
        shift_bits(8, 32'h96, d);
        tick(1, 0, 0);
        tap_en = 1'b0;
        repeat (3) tick(1, 0, 0);
        chk("R3 update withheld while disabled", up_n - u0, 0);
        tap_en = 1'b1;
        tick(0, 0, 0);
        chk("R8 single update after enable", up_n - u0, 1);

        // Five ones reach reset from every state along a full walk.
        for (int k = 0; k <= 17; k++) begin
            scan_ir(OP_BYP, ir_o);
            for (int j = 0; j < k; j++) tick(WALK[j][0], 1'b0, -1);
            repeat (5) tick(1, 0, -1);
            tick(0, 0, 0);
            scan_dr(32, 32'h0, d);
            chk("R2 five ones reload identification", d, ID_EXP);
        end

        // Asynchronous reset in the middle of an emulation scan.
        scan_ir(OP_EMU, ir_o);
        enter_dr();
        tick(0, 1, 1);
        tick(0, 1, 1);
        #3;
        rst_n = 1'b0;
        #2;
        chk("R1 async tdo_oe", {31'd0, tdo_oe}, 0);
        chk("R1 async tdo", {31'd0, tdo}, 0);
        chk("R1 async emu_sel", {31'd0, emu_sel}, 0);
        chk("R1 async emu_shift", {31'd0, emu_shift}, 0);
        @(posedge tck); #1;
        rst_n = 1'b1;
        goto_idle();
        scan_dr(32, 32'h0, d);
        chk("R1 identification after async reset", d, ID_EXP);

        chk("R9 tdo_oe only in shift states", oe_err, 0);
        chk("R9 tdo low when not enabled", low_err, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule